// File: doc/BRIEF.md
# Termination and Precharge Policy Unit

This unit decides, for every memory access, which of the chip selects turn on their on-die termination and whether the command carries an auto-precharge. Each chip select has its own 3-bit policy code for reads and its own for writes. A code can say never, only when this chip select is the target, only when another one is the target, or on every access of that kind. Read termination is allowed only when CAS latency plus additive latency reaches 3. Write termination is allowed only when write latency plus additive latency reaches 3.

The termination vector is registered when the access is accepted and is then held for a programmable number of cycles. A small two-state machine controls the hold. In `WIN_IDLE` the outputs are low. An access with a non-zero hold length takes the transition *arm* into `WIN_HOLD`. In `WIN_HOLD`, a new access takes *reload*, which computes the vector again and restarts the count. When the count runs out, *expire* returns the machine to `WIN_IDLE`. An access with a hold length of zero takes *drop* back to `WIN_IDLE`.

The auto-precharge flag is combinational and valid only in the strobe cycle. It is set when the target chip select has its force bit set. It is also set when the global burst-to-precharge count is zero, which means the global auto-precharge mode is on.

Top module: `odt_ap_policy`

## Requirements
- R1: After the synchronous active-high reset `rst`, `odt_o` is all zero, and `ap_o` is zero while `acc_vld` is low.
- R2: The policy code of chip select i lies at bits [3i+2:3i] of its field. Code 000 never asserts. Code 001 asserts only when `acc_cs` equals i. Code 010 asserts only when `acc_cs` differs from i. Code 100 asserts on every access.
- R3: Codes 011, 101, 110 and 111 behave as 000.
- R4: Reads (`acc_wr`=0) use `rd_odt_cfg` only. Writes (`acc_wr`=1) use `wr_odt_cfg` only.
- R5: When `cas_lat`+`add_lat` is below 3, no read asserts termination. A sum of exactly 3 allows it.
- R6: When `wr_lat`+`add_lat` is below 3, no write asserts termination. A sum of exactly 3 allows it.
- R7: An access accepted on clock edge k with `hold_len`=N>0 drives its vector on `odt_o` from edge k+1 up to and including the cycle after edge k+N. After that, `odt_o` returns to zero. With N=0 the output stays zero.
- R8: An access during the hold computes the vector again and restarts the N-cycle count.
- R9: An access to a chip select whose `ap_force` bit is 1 drives `ap_o` high in that cycle.
- R10: For a chip select whose `ap_force` bit is 0, `ap_o` is high exactly when `pre_gap` equals zero.
- R11: `ap_o` is low in every cycle in which `acc_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_cs | input | CSW | Target chip-select index |
| rd_odt_cfg | input | 3*NUM_CS | Read termination codes, 3 bits per chip select |
| wr_odt_cfg | input | 3*NUM_CS | Write termination codes, 3 bits per chip select |
| ap_force | input | NUM_CS | Per-chip-select forced auto-precharge |
| pre_gap | input | GAP_W | Global burst-to-precharge count, zero means global auto-precharge |
| cas_lat | input | LAT_W | CAS latency in cycles |
| add_lat | input | LAT_W | Additive latency in cycles |
| wr_lat | input | LAT_W | Write latency in cycles |
| hold_len | input | LEN_W | Termination hold length in cycles |
| odt_o | output | NUM_CS | Per-chip-select termination enable |
| ap_o | output | 1 | Auto-precharge flag for the current access |

## Verification
The bench builds the unit with its defaults: four chip selects, 4-bit latency and hold fields, and a 10-bit precharge count. Four chip selects are enough to mix every legal policy code with a reserved one in a single configuration word, so one access checks self, peer, all and never at the same time. The 4-bit latency fields reach the boundary sums 2 and 3 for both the read and the write gates. The hold field covers the zero-length case, a single reload inside a 3-cycle window, and the natural expiry.

// File: rtl/odt_pol_pkg.sv
package odt_pol_pkg;

    typedef enum logic [2:0] {
        TERM_NEVER = 3'b000,
        TERM_SELF  = 3'b001,
        TERM_PEERS = 3'b010,
        TERM_ALL   = 3'b100
    } term_pol_e;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_HOLD = 1'b1
    } win_state_e;

    localparam int unsigned CODE_W  = 3;
    localparam int unsigned LAT_MIN = 3;

    // Decide termination for one chip select from its code and target match.
    function automatic logic term_want(input logic [CODE_W-1:0] code, input logic hit);
        logic r;
        case (code)
            TERM_SELF:  r = hit;
            TERM_PEERS: r = !hit;
            TERM_ALL:   r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic code_legal(input logic [CODE_W-1:0] code);
        return (code == TERM_NEVER) || (code == TERM_SELF) ||
               (code == TERM_PEERS) || (code == TERM_ALL);
    endfunction

endpackage

// File: rtl/odt_lat_gate.sv
module odt_lat_gate #(
    parameter int unsigned LAT_W = 4
) (
    input  logic [LAT_W-1:0] cas_lat,
    input  logic [LAT_W-1:0] add_lat,
    input  logic [LAT_W-1:0] wr_lat,
    output logic             rd_ok,
    output logic             wr_ok
);
    import odt_pol_pkg::*;

    localparam int unsigned SUM_W = LAT_W + 1;

    logic [SUM_W-1:0] rd_sum;
    logic [SUM_W-1:0] wr_sum;

    always_comb begin
        rd_sum = {1'b0, cas_lat} + {1'b0, add_lat};
        wr_sum = {1'b0, wr_lat}  + {1'b0, add_lat};
        rd_ok  = rd_sum >= SUM_W'(LAT_MIN);
        wr_ok  = wr_sum >= SUM_W'(LAT_MIN);
    end

endmodule

// File: rtl/odt_cs_decode.sv
module odt_cs_decode #(
    parameter int unsigned CSW   = 2,
    parameter int unsigned MY_CS = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_wr,
    input  logic [CSW-1:0] acc_cs,
    input  logic [2:0]     rd_code,
    input  logic [2:0]     wr_code,
    input  logic           rd_ok,
    input  logic           wr_ok,
    output logic           want
);
    import odt_pol_pkg::*;

    logic hit;
    logic rd_want;
    logic wr_want;

    always_comb begin
        hit     = (acc_cs == CSW'(MY_CS));
        rd_want = term_want(rd_code, hit) && rd_ok;
        wr_want = term_want(wr_code, hit) && wr_ok;
        want    = acc_wr ? wr_want : rd_want;
    end

    // Reserved read codes never request termination.
    assert_rd_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        (!acc_wr && !code_legal(rd_code)) |-> !want);
    // Reserved write codes never request termination.
    assert_wr_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !code_legal(wr_code)) |-> !want);

endmodule

// File: rtl/odt_hold_fsm.sv
module odt_hold_fsm #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic [LEN_W-1:0]  hold_len,
    input  logic [NUM_CS-1:0] vec_in,
    output logic [NUM_CS-1:0] odt_o
);
    import odt_pol_pkg::*;

    win_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic [NUM_CS-1:0] vec_q, vec_d;
    logic              len_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vec_q   <= vec_d;
        end
    end

    always_comb begin
        len_zero = (hold_len == '0);
        state_d  = state_q;
        cnt_d    = cnt_q;
        vec_d    = vec_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (acc_vld && !len_zero) begin           // arm
                    state_d = WIN_HOLD;
                    cnt_d   = hold_len - LEN_W'(1);
                    vec_d   = vec_in;
                end
            end
            WIN_HOLD: begin
                if (acc_vld && !len_zero) begin           // reload
                    cnt_d   = hold_len - LEN_W'(1);
                    vec_d   = vec_in;
                end else if (acc_vld) begin               // drop
                    state_d = WIN_IDLE;
                    cnt_d   = '0;
                    vec_d   = '0;
                end else if (cnt_q == '0) begin           // expire
                    state_d = WIN_IDLE;
                    vec_d   = '0;
                end else begin
                    cnt_d   = cnt_q - LEN_W'(1);
                end
            end
            default: begin
                state_d = WIN_IDLE;
                cnt_d   = '0;
                vec_d   = '0;
            end
        endcase
    end

    always_comb begin
        odt_o = (state_q == WIN_HOLD) ? vec_q : '0;
    end

    assert_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && hold_len != '0) |=> odt_o == $past(vec_in));
    assert_expire_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_HOLD && cnt_q == '0 && !acc_vld) |=> odt_o == '0);
    assert_zero_len_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && hold_len == '0) |=> odt_o == '0);
    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_HOLD && acc_vld && hold_len != '0) |=> state_q == WIN_HOLD);

endmodule

// File: rtl/ap_select.sv
module ap_select #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CSW    = 2,
    parameter int unsigned GAP_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic [CSW-1:0]    acc_cs,
    input  logic [NUM_CS-1:0] ap_force,
    input  logic [GAP_W-1:0]  pre_gap,
    output logic              ap_o
);
    logic global_mode;
    logic forced;

    always_comb begin
        global_mode = (pre_gap == '0);
        forced      = ap_force[acc_cs];
        ap_o        = acc_vld && (forced || global_mode);
    end

    assert_ap_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |-> !ap_o);
    assert_ap_force_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && ap_force[acc_cs]) |-> ap_o);
    assert_ap_global_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && pre_gap == '0) |-> ap_o);

endmodule

// File: rtl/odt_ap_policy.sv
module odt_ap_policy #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned LAT_W  = 4,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned GAP_W  = 10,
    localparam int unsigned CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned CFG_W = 3 * NUM_CS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [CSW-1:0]    acc_cs,
    input  logic [CFG_W-1:0]  rd_odt_cfg,
    input  logic [CFG_W-1:0]  wr_odt_cfg,
    input  logic [NUM_CS-1:0] ap_force,
    input  logic [GAP_W-1:0]  pre_gap,
    input  logic [LAT_W-1:0]  cas_lat,
    input  logic [LAT_W-1:0]  add_lat,
    input  logic [LAT_W-1:0]  wr_lat,
    input  logic [LEN_W-1:0]  hold_len,
    output logic [NUM_CS-1:0] odt_o,
    output logic              ap_o
);
    logic              rd_ok;
    logic              wr_ok;
    logic [NUM_CS-1:0] want_vec;

    odt_lat_gate #(.LAT_W(LAT_W)) u_gate (
        .cas_lat (cas_lat),
        .add_lat (add_lat),
        .wr_lat  (wr_lat),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        odt_cs_decode #(.CSW(CSW), .MY_CS(g)) u_dec (
            .clk     (clk),
            .rst     (rst),
            .acc_wr  (acc_wr),
            .acc_cs  (acc_cs),
            .rd_code (rd_odt_cfg[3*g +: 3]),
            .wr_code (wr_odt_cfg[3*g +: 3]),
            .rd_ok   (rd_ok),
            .wr_ok   (wr_ok),
            .want    (want_vec[g])
        );
    end

    odt_hold_fsm #(.NUM_CS(NUM_CS), .LEN_W(LEN_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .acc_vld  (acc_vld),
        .hold_len (hold_len),
        .vec_in   (want_vec),
        .odt_o    (odt_o)
    );

    ap_select #(.NUM_CS(NUM_CS), .CSW(CSW), .GAP_W(GAP_W)) u_ap (
        .clk      (clk),
        .rst      (rst),
        .acc_vld  (acc_vld),
        .acc_cs   (acc_cs),
        .ap_force (ap_force),
        .pre_gap  (pre_gap),
        .ap_o     (ap_o)
    );

    assert_rd_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !acc_wr && !rd_ok) |=> odt_o == '0);
    assert_wr_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_wr && !wr_ok) |=> odt_o == '0);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> odt_o == '0);

endmodule

// File: tb/tb_odt_ap_policy.sv
module tb_odt_ap_policy;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_vld, acc_wr;
    logic [1:0]  acc_cs;
    logic [11:0] rd_odt_cfg, wr_odt_cfg;
    logic [3:0]  ap_force;
    logic [9:0]  pre_gap;
    logic [3:0]  cas_lat, add_lat, wr_lat, hold_len;
    logic [3:0]  odt_o;
    logic        ap_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    odt_ap_policy dut (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_cs(acc_cs),
        .rd_odt_cfg(rd_odt_cfg), .wr_odt_cfg(wr_odt_cfg), .ap_force(ap_force),
        .pre_gap(pre_gap), .cas_lat(cas_lat), .add_lat(add_lat), .wr_lat(wr_lat),
        .hold_len(hold_len), .odt_o(odt_o), .ap_o(ap_o)
    );

    // {write, cs, read codes (octal digit per CS, CS3 first), write codes, expected odt}
    localparam logic [30:0] VEC [10] = '{
        {1'b0, 2'd1, 12'o1111, 12'o0000, 4'b0010},  // R2 self only
        {1'b0, 2'd1, 12'o2222, 12'o0000, 4'b1101},  // R2 peers only
        {1'b0, 2'd0, 12'o4444, 12'o0000, 4'b1111},  // R2 all
        {1'b0, 2'd2, 12'o4210, 12'o0000, 4'b1000},  // R2 mixed, target 2
        {1'b0, 2'd1, 12'o4210, 12'o0000, 4'b1110},  // R2 mixed, target 1
        {1'b0, 2'd0, 12'o3567, 12'o0000, 4'b0000},  // R3 reserved read
        {1'b1, 2'd0, 12'o4444, 12'o0000, 4'b0000},  // R4 write ignores read codes
        {1'b1, 2'd3, 12'o0000, 12'o1204, 4'b1101},  // R4 write codes
        {1'b1, 2'd2, 12'o4444, 12'o7121, 4'b0110},  // R3 reserved write, R4
        {1'b0, 2'd3, 12'o1111, 12'o4444, 4'b1000}   // R4 read ignores write codes
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe one access; returns at the negedge after the accepting edge.
    task automatic access(input logic wr, input logic [1:0] cs);
        @(negedge clk);
        acc_vld = 1'b1; acc_wr = wr; acc_cs = cs;
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_vld = 0; acc_wr = 0; acc_cs = 0;
        rd_odt_cfg = '0; wr_odt_cfg = '0; ap_force = '0; pre_gap = 10'd5;
        cas_lat = 4'd3; add_lat = 4'd0; wr_lat = 4'd3; hold_len = 4'd2;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 odt after reset", 32'(odt_o), 32'h0);
        chk("R1 ap after reset", 32'(ap_o), 32'h0);

        // Table walk
        for (int i = 0; i < 10; i++) begin
            rd_odt_cfg = VEC[i][27:16];
            wr_odt_cfg = VEC[i][15:4];
            access(VEC[i][30], VEC[i][29:28]);
            chk($sformatf("R2/R3/R4 vector %0d", i), 32'(odt_o), 32'(VEC[i][3:0]));
            idle(2);
            chk($sformatf("R7 quiet after vector %0d", i), 32'(odt_o), 32'h0);
        end

        // R7 window of 3
        rd_odt_cfg = 12'o4444; hold_len = 4'd3;
        access(1'b0, 2'd0);
        chk("R7 window c1", 32'(odt_o), 32'hF);
        idle(1); chk("R7 window c2", 32'(odt_o), 32'hF);
        idle(1); chk("R7 window c3", 32'(odt_o), 32'hF);
        idle(1); chk("R7 window end", 32'(odt_o), 32'h0);

        // R7 zero length
        hold_len = 4'd0;
        access(1'b0, 2'd0);
        chk("R7 zero length", 32'(odt_o), 32'h0);
        idle(1); chk("R7 zero length later", 32'(odt_o), 32'h0);

        // R8 reload
        hold_len = 4'd3; rd_odt_cfg = 12'o1111;
        access(1'b0, 2'd0);
        chk("R8 first vector", 32'(odt_o), 32'h1);
        idle(1);
        access(1'b0, 2'd2);
        chk("R8 reloaded vector", 32'(odt_o), 32'h4);
        idle(1); chk("R8 hold c2", 32'(odt_o), 32'h4);
        idle(1); chk("R8 hold c3", 32'(odt_o), 32'h4);
        idle(1); chk("R8 end", 32'(odt_o), 32'h0);

        // R5 read latency gate
        hold_len = 4'd1; rd_odt_cfg = 12'o4444;
        cas_lat = 4'd1; add_lat = 4'd1;
        access(1'b0, 2'd0);
        chk("R5 sum 2 blocks read", 32'(odt_o), 32'h0);
        cas_lat = 4'd2;
        access(1'b0, 2'd0);
        chk("R5 sum 3 allows read", 32'(odt_o), 32'hF);

        // R6 write latency gate
        wr_odt_cfg = 12'o4444; add_lat = 4'd0; wr_lat = 4'd2;
        access(1'b1, 2'd1);
        chk("R6 sum 2 blocks write", 32'(odt_o), 32'h0);
        wr_lat = 4'd3;
        access(1'b1, 2'd1);
        chk("R6 sum 3 allows write", 32'(odt_o), 32'hF);

        // Auto-precharge
        ap_force = 4'b0010; pre_gap = 10'd5;
        @(negedge clk);
        acc_vld = 1; acc_cs = 2'd1; #1;
        chk("R9 forced cs", 32'(ap_o), 32'h1);
        acc_cs = 2'd0; #1;
        chk("R10 not forced, gap nonzero", 32'(ap_o), 32'h0);
        pre_gap = 10'd0; #1;
        chk("R10 not forced, gap zero", 32'(ap_o), 32'h1);
        @(negedge clk);
        acc_vld = 0; #1;
        chk("R11 no strobe", 32'(ap_o), 32'h0);
        ap_force = 4'hF; #1;
        chk("R11 no strobe with force", 32'(ap_o), 32'h0);

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule